// File: doc/BRIEF.md
# External-Memory Controller User Port

This block is one user-facing port of a multi-port external-memory controller. Client logic queues commands (operation code, byte address and burst length), streams write words with per-byte masks, and drains read words. Each of these three paths runs on its own user clock. The controller core runs on a separate controller clock. Every path is an asynchronous FIFO whose pointers cross the clock boundary in Gray code.

On the controller side, a simple pop/push handshake stands in for the arbiter and the DRAM sequencer. Popping a write-type command arms a beat counter for that command's burst. Write words can only be taken while a burst is armed. A pop that finds the write FIFO empty is reported as an underrun. A read word pushed into a full read FIFO is dropped and reported as an overflow. Each path keeps a sticky error flag, which is brought into the user clock domain of that path.

Fill counts are computed in the domain that reads them. Because the far pointer passes through a synchroniser first, a count may lag the true fill level by a few cycles.

Top module: `mport_user_port`

## Requirements
- R1: After reset, all FIFOs are empty: `cmd_empty`, `wr_empty` and `rd_empty` are 1, both counts are 0, all full flags and error flags are 0, and `ctl_cmd_valid` is 0.
- R2: The command FIFO holds 4 commands. Commands are delivered to the controller in order with their instruction (3 bits), address and burst-length field unchanged. `cmd_full` rises once 4 commands are queued. An unpopped head command stays stable.
- R3: A command push while `cmd_full` is 1 is ignored: the queued commands are unchanged and no fifth command appears. It sets `cmd_error`, which stays 1 until reset.
- R4: The write FIFO holds 64 words of 32 data bits and 4 mask bits, with mask bit k belonging to data byte k. Words reach `ctl_wr_data`/`ctl_wr_mask` in order. `wr_count` and `wr_full` (count of 64) are computed in the write clock domain, and `wr_empty` is 1 when the count is 0.
- R5: A `wr_en` while `wr_full` is 1 is ignored, so no extra word is ever delivered.
- R6: Instruction codes are 000 write, 001 read, 010 write with auto-precharge, 011 read with auto-precharge and 1xx refresh. Popping code 000 or 010 arms a burst of (burst field + 1) write beats. A `ctl_wr_pop` while no burst is armed has no effect, and read and refresh commands arm nothing.
- R7: A `ctl_wr_pop` during an armed burst while the write FIFO is empty drives `ctl_wr_underrun` high in that controller cycle and uses up one beat. It sets a sticky error that appears on `wr_error` in the write clock domain.
- R8: The read FIFO holds 64 words. Words reach `rd_data` in push order. `rd_count` and `rd_full` are computed in the read clock domain, and an `rd_en` while `rd_empty` is 1 is ignored.
- R9: A `ctl_rd_push` while the read FIFO is full drops the word and drives `ctl_rd_overflow` high in that cycle. It sets a sticky error that appears on `rd_error` in the read clock domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| cmd_clk | input | 1 | User command clock |
| cmd_en | input | 1 | Push a command |
| cmd_instr | input | 3 | Instruction code |
| cmd_addr | input | 30 | Byte address |
| cmd_blen | input | 6 | Burst length minus one |
| cmd_full | output | 1 | Command FIFO full (command clock) |
| cmd_empty | output | 1 | Command FIFO empty (command clock) |
| cmd_error | output | 1 | Sticky: push while full |
| wr_clk | input | 1 | User write clock |
| wr_en | input | 1 | Push a write word |
| wr_data | input | 32 | Write data |
| wr_mask | input | 4 | Per-byte mask |
| wr_full | output | 1 | Write FIFO full |
| wr_empty | output | 1 | Write FIFO empty |
| wr_count | output | 7 | Write FIFO fill (write clock) |
| wr_error | output | 1 | Sticky underrun error (write clock) |
| rd_clk | input | 1 | User read clock |
| rd_en | input | 1 | Pop a read word |
| rd_data | output | 32 | Head read word |
| rd_full | output | 1 | Read FIFO full |
| rd_empty | output | 1 | Read FIFO empty |
| rd_count | output | 7 | Read FIFO fill (read clock) |
| rd_error | output | 1 | Sticky overflow error (read clock) |
| ctl_clk | input | 1 | Controller clock |
| ctl_cmd_valid | output | 1 | A command is available |
| ctl_cmd_instr | output | 3 | Head command instruction |
| ctl_cmd_addr | output | 30 | Head command address |
| ctl_cmd_blen | output | 6 | Head command burst field |
| ctl_cmd_pop | input | 1 | Take head command |
| ctl_wr_pop | input | 1 | Take a write beat |
| ctl_wr_data | output | 32 | Head write data |
| ctl_wr_mask | output | 4 | Head write mask |
| ctl_wr_underrun | output | 1 | Beat taken from an empty FIFO |
| ctl_rd_push | input | 1 | Deliver a read word |
| ctl_rd_data | input | 32 | Read word from memory |
| ctl_rd_overflow | output | 1 | Read word dropped because the FIFO is full |

## Verification
The assertions check the following on every cycle:
- A full command push sets the command error flag, and all three error flags stay set.
- Counts never exceed the depth, and full and empty are never high together.
- An unpopped head command holds still.

Only the bench scenarios can show the rest:
- Ordering and integrity across the clock crossing.
- Burst arming by write-type commands only, and beats taken outside a burst being ignored.
- The exact cycle in which underrun and overflow pulse, and the propagation of the sticky errors into the user domains.
- Dropped words and ignored pushes never showing up on the far side.

// File: rtl/mport_pkg.sv
package mport_pkg;
   typedef enum logic [2:0] {
      OP_WRITE    = 3'b000,
      OP_READ     = 3'b001,
      OP_WRITE_AP = 3'b010,
      OP_READ_AP  = 3'b011,
      OP_REFRESH  = 3'b100
   } mport_op_e;

   function automatic logic op_is_write(input logic [2:0] op);
      return (op[2] == 1'b0) && (op[0] == 1'b0);
   endfunction
endpackage

// File: rtl/mport_sync.sv
module mport_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mport_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/mport_afifo.sv
module mport_afifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4,
   parameter int SYNC  = 2,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = AW + 1
) (
   input  logic          rst_n,
   input  logic          wclk,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   output logic [PW-1:0] wcount,
   input  logic          rclk,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic [PW-1:0] rcount
);
   if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("mport_afifo: DEPTH must be a power of two of at least 4");
   end

   function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wbin, wgray, rbin, rgray;
   logic [PW-1:0] rgray_w, wgray_r;
   logic          wfull, rempty, wr_ok, rd_ok;

   mport_sync #(.W(PW), .STAGES(SYNC)) i_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_w));
   mport_sync #(.W(PW), .STAGES(SYNC)) i_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_r));

   assign wfull  = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
   assign wr_ok  = push && !wfull;
   assign wcount = wbin - from_gray(rgray_w);

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wr_ok) begin
         wbin  <= wbin + 1'b1;
         wgray <= to_gray(wbin + 1'b1);
      end
   end

   always_ff @(posedge wclk) begin
      if (wr_ok) mem[wbin[AW-1:0]] <= wdata;
   end

   assign rempty = (rgray == wgray_r);
   assign rd_ok  = pop && !rempty;
   assign rcount = from_gray(wgray_r) - rbin;
   assign rdata  = mem[rbin[AW-1:0]];

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (rd_ok) begin
         rbin  <= rbin + 1'b1;
         rgray <= to_gray(rbin + 1'b1);
      end
   end
endmodule

// File: rtl/mport_user_port.sv
module mport_user_port #(
   parameter int ADDR_W      = 30,
   parameter int DATA_W      = 32,
   parameter int BLEN_W      = 6,
   parameter int CMD_DEPTH   = 4,
   parameter int DATA_DEPTH  = 64,
   parameter int SYNC_STAGES = 2,
   localparam int MASK_W     = DATA_W / 8,
   localparam int DCNT_W     = $clog2(DATA_DEPTH) + 1
) (
   input  logic              rst_n,
   input  logic              cmd_clk,
   input  logic              cmd_en,
   input  logic [2:0]        cmd_instr,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [BLEN_W-1:0] cmd_blen,
   output logic              cmd_full,
   output logic              cmd_empty,
   output logic              cmd_error,
   input  logic              wr_clk,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [MASK_W-1:0] wr_mask,
   output logic              wr_full,
   output logic              wr_empty,
   output logic [DCNT_W-1:0] wr_count,
   output logic              wr_error,
   input  logic              rd_clk,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_full,
   output logic              rd_empty,
   output logic [DCNT_W-1:0] rd_count,
   output logic              rd_error,
   input  logic              ctl_clk,
   output logic              ctl_cmd_valid,
   output logic [2:0]        ctl_cmd_instr,
   output logic [ADDR_W-1:0] ctl_cmd_addr,
   output logic [BLEN_W-1:0] ctl_cmd_blen,
   input  logic              ctl_cmd_pop,
   input  logic              ctl_wr_pop,
   output logic [DATA_W-1:0] ctl_wr_data,
   output logic [MASK_W-1:0] ctl_wr_mask,
   output logic              ctl_wr_underrun,
   input  logic              ctl_rd_push,
   input  logic [DATA_W-1:0] ctl_rd_data,
   output logic              ctl_rd_overflow
);
   import mport_pkg::*;

   localparam int CMD_W  = 3 + ADDR_W + BLEN_W;
   localparam int CCNT_W = $clog2(CMD_DEPTH) + 1;
   localparam int WF_W   = DATA_W + MASK_W;
   localparam int BEAT_W = BLEN_W + 1;

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("mport_user_port: DATA_W must be a whole number of bytes");
   end

   // command path: cmd_clk -> ctl_clk
   logic [CCNT_W-1:0] c_wcount, c_rcount;
   logic [CMD_W-1:0]  c_head;

   mport_afifo #(.W(CMD_W), .DEPTH(CMD_DEPTH), .SYNC(SYNC_STAGES)) i_cmd_fifo (
      .rst_n(rst_n),
      .wclk(cmd_clk), .push(cmd_en), .wdata({cmd_instr, cmd_addr, cmd_blen}), .wcount(c_wcount),
      .rclk(ctl_clk), .pop(ctl_cmd_pop), .rdata(c_head), .rcount(c_rcount));

   assign cmd_full  = (c_wcount == CCNT_W'(CMD_DEPTH));
   assign cmd_empty = (c_wcount == '0);
   assign ctl_cmd_valid = (c_rcount != '0);
   assign {ctl_cmd_instr, ctl_cmd_addr, ctl_cmd_blen} = c_head;

   always_ff @(posedge cmd_clk or negedge rst_n) begin
      if (!rst_n)                  cmd_error <= 1'b0;
      else if (cmd_en && cmd_full) cmd_error <= 1'b1;
   end

   // write-burst tracking in the controller domain
   logic [BEAT_W-1:0] beats_left;
   logic              burst_on, cmd_take;

   assign burst_on = (beats_left != '0);
   assign cmd_take = ctl_cmd_pop && ctl_cmd_valid;

   always_ff @(posedge ctl_clk or negedge rst_n) begin
      if (!rst_n)
         beats_left <= '0;
      else if (cmd_take && op_is_write(ctl_cmd_instr))
         beats_left <= {1'b0, ctl_cmd_blen} + BEAT_W'(1);
      else if (ctl_wr_pop && burst_on)
         beats_left <= beats_left - 1'b1;
   end

   // write path: wr_clk -> ctl_clk
   logic [DCNT_W-1:0] w_wcount, w_rcount;

   mport_afifo #(.W(WF_W), .DEPTH(DATA_DEPTH), .SYNC(SYNC_STAGES)) i_wr_fifo (
      .rst_n(rst_n),
      .wclk(wr_clk), .push(wr_en), .wdata({wr_mask, wr_data}), .wcount(w_wcount),
      .rclk(ctl_clk), .pop(ctl_wr_pop && burst_on), .rdata({ctl_wr_mask, ctl_wr_data}),
      .rcount(w_rcount));

   assign wr_count = w_wcount;
   assign wr_full  = (w_wcount == DCNT_W'(DATA_DEPTH));
   assign wr_empty = (w_wcount == '0);
   assign ctl_wr_underrun = ctl_wr_pop && burst_on && (w_rcount == '0);

   // read path: ctl_clk -> rd_clk
   logic [DCNT_W-1:0] r_wcount, r_rcount;

   mport_afifo #(.W(DATA_W), .DEPTH(DATA_DEPTH), .SYNC(SYNC_STAGES)) i_rd_fifo (
      .rst_n(rst_n),
      .wclk(ctl_clk), .push(ctl_rd_push), .wdata(ctl_rd_data), .wcount(r_wcount),
      .rclk(rd_clk), .pop(rd_en), .rdata(rd_data), .rcount(r_rcount));

   assign rd_count = r_rcount;
   assign rd_full  = (r_rcount == DCNT_W'(DATA_DEPTH));
   assign rd_empty = (r_rcount == '0);
   assign ctl_rd_overflow = ctl_rd_push && (r_wcount == DCNT_W'(DATA_DEPTH));

   // sticky errors, raised in the controller domain, carried to user domains
   logic wr_err_ctl, rd_err_ctl;

   always_ff @(posedge ctl_clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_err_ctl <= 1'b0;
         rd_err_ctl <= 1'b0;
      end else begin
         if (ctl_wr_underrun) wr_err_ctl <= 1'b1;
         if (ctl_rd_overflow) rd_err_ctl <= 1'b1;
      end
   end

   mport_sync #(.W(1), .STAGES(SYNC_STAGES)) i_wr_err_sync (
      .clk(wr_clk), .rst_n(rst_n), .d(wr_err_ctl), .q(wr_error));
   mport_sync #(.W(1), .STAGES(SYNC_STAGES)) i_rd_err_sync (
      .clk(rd_clk), .rst_n(rst_n), .d(rd_err_ctl), .q(rd_error));
endmodule

// File: rtl/mport_user_port_chk.sv
module mport_user_port_chk #(
   parameter int ADDR_W     = 30,
   parameter int BLEN_W     = 6,
   parameter int DATA_DEPTH = 64,
   localparam int DCNT_W    = $clog2(DATA_DEPTH) + 1
) (
   input logic              rst_n,
   input logic              cmd_clk,
   input logic              wr_clk,
   input logic              rd_clk,
   input logic              ctl_clk,
   input logic              cmd_en,
   input logic              cmd_full,
   input logic              cmd_error,
   input logic              wr_full,
   input logic              wr_empty,
   input logic [DCNT_W-1:0] wr_count,
   input logic              wr_error,
   input logic              rd_full,
   input logic              rd_empty,
   input logic [DCNT_W-1:0] rd_count,
   input logic              rd_error,
   input logic              ctl_cmd_valid,
   input logic              ctl_cmd_pop,
   input logic [2:0]        ctl_cmd_instr,
   input logic [ADDR_W-1:0] ctl_cmd_addr,
   input logic [BLEN_W-1:0] ctl_cmd_blen
);
   p_cmd_err_set_r3: assert property (@(posedge cmd_clk) disable iff (!rst_n)
      (cmd_en && cmd_full) |=> cmd_error);

   p_cmd_err_sticky_r3: assert property (@(posedge cmd_clk) disable iff (!rst_n)
      cmd_error |=> cmd_error);

   p_wr_err_sticky_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
      wr_error |=> wr_error);

   p_rd_err_sticky_r9: assert property (@(posedge rd_clk) disable iff (!rst_n)
      rd_error |=> rd_error);

   p_wr_count_bound_r4: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_count <= DCNT_W'(DATA_DEPTH)) && !(wr_full && wr_empty));

   p_rd_count_bound_r8: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_count <= DCNT_W'(DATA_DEPTH)) && !(rd_full && rd_empty));

   p_cmd_head_hold_r2: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      (ctl_cmd_valid && !ctl_cmd_pop) |=>
         (ctl_cmd_valid && $stable({ctl_cmd_instr, ctl_cmd_addr, ctl_cmd_blen})));
endmodule

bind mport_user_port mport_user_port_chk #(
   .ADDR_W(ADDR_W), .BLEN_W(BLEN_W), .DATA_DEPTH(DATA_DEPTH)
) i_mport_user_port_chk (.*);

// File: tb/test_mport_user_port.sv
`timescale 1ns/1ps
module test_mport_user_port;
   logic        rst_n = 1'b0;
   logic        cmd_clk = 0, wr_clk = 0, rd_clk = 0, ctl_clk = 0;
   logic        cmd_en = 0;
   logic [2:0]  cmd_instr = '0;
   logic [29:0] cmd_addr = '0;
   logic [5:0]  cmd_blen = '0;
   logic        cmd_full, cmd_empty, cmd_error;
   logic        wr_en = 0;
   logic [31:0] wr_data = '0;
   logic [3:0]  wr_mask = '0;
   logic        wr_full, wr_empty, wr_error;
   logic [6:0]  wr_count;
   logic        rd_en = 0;
   logic [31:0] rd_data;
   logic        rd_full, rd_empty, rd_error;
   logic [6:0]  rd_count;
   logic        ctl_cmd_valid;
   logic [2:0]  ctl_cmd_instr;
   logic [29:0] ctl_cmd_addr;
   logic [5:0]  ctl_cmd_blen;
   logic        ctl_cmd_pop = 0, ctl_wr_pop = 0, ctl_rd_push = 0;
   logic [31:0] ctl_wr_data, ctl_rd_data = '0;
   logic [3:0]  ctl_wr_mask;
   logic        ctl_wr_underrun, ctl_rd_overflow;

   int n_tests = 0, n_fail = 0;

   always #4 ctl_clk = ~ctl_clk;   // 125 MHz
   always #5 cmd_clk = ~cmd_clk;
   always #6 wr_clk  = ~wr_clk;
   always #7 rd_clk  = ~rd_clk;

   mport_user_port i_mport_user_port (.*);

   function automatic logic [31:0] wd(input int i);
      return {8'(i) ^ 8'h5A, ~8'(i), 8'(i + 3), 8'(i * 7)};
   endfunction
   function automatic logic [3:0] wm(input int i);
      return 4'(i) ^ 4'hA;
   endfunction
   function automatic logic [31:0] rdw(input int j);
      return 32'hC0DE_0000 + 32'(j * 37);
   endfunction

   task automatic chk(input string req, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push_cmd(input logic [2:0] op, input logic [29:0] a, input logic [5:0] bl);
      @(negedge cmd_clk);
      cmd_en = 1; cmd_instr = op; cmd_addr = a; cmd_blen = bl;
      @(negedge cmd_clk);
      cmd_en = 0;
   endtask

   task automatic pop_cmd(input string req, input logic [2:0] op, input logic [29:0] a,
                          input logic [5:0] bl);
      @(negedge ctl_clk);
      chk(req, "cmd valid", 64'(ctl_cmd_valid), 64'(1));
      chk(req, "cmd fields", {ctl_cmd_instr, ctl_cmd_addr, ctl_cmd_blen}, {op, a, bl});
      ctl_cmd_pop = 1;
      @(negedge ctl_clk);
      ctl_cmd_pop = 0;
   endtask

   task automatic push_wr(input int i);
      @(negedge wr_clk);
      wr_en = 1; wr_data = wd(i); wr_mask = wm(i);
      @(negedge wr_clk);
      wr_en = 0;
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #95 rst_n = 1'b1;
      repeat (3) @(negedge ctl_clk);

      // R1 reset state
      chk("R1", "cmd_empty/full/err", {cmd_empty, cmd_full, cmd_error}, 3'b100);
      chk("R1", "wr flags", {wr_empty, wr_full, wr_error, wr_count}, {3'b100, 7'd0});
      chk("R1", "rd flags", {rd_empty, rd_full, rd_error, rd_count}, {3'b100, 7'd0});
      chk("R1", "ctl_cmd_valid", 64'(ctl_cmd_valid), 64'(0));

      // R4/R5: fill the write FIFO, then one extra push
      @(negedge wr_clk);
      for (int i = 0; i < 65; i++) begin
         wr_en = 1; wr_data = wd(i); wr_mask = wm(i);
         @(negedge wr_clk);
         if (i == 63) chk("R4", "wr_full after 64", {wr_full, wr_count}, {1'b1, 7'd64});
      end
      wr_en = 0;
      chk("R5", "wr_count after push while full", 64'(wr_count), 64'(64));

      // R2/R6: 64-beat write burst
      push_cmd(3'b000, 30'h0000_0100, 6'd63);
      repeat (6) @(negedge ctl_clk);
      pop_cmd("R2", 3'b000, 30'h0000_0100, 6'd63);
      for (int i = 0; i < 64; i++) begin
         @(negedge ctl_clk);
         ctl_wr_pop = 1;
         #1;
         chk("R4", $sformatf("wr word %0d", i), {ctl_wr_mask, ctl_wr_data}, {wm(i), wd(i)});
         chk("R7", "no underrun in filled burst", 64'(ctl_wr_underrun), 64'(0));
      end
      @(negedge ctl_clk);
      ctl_wr_pop = 0;
      repeat (6) @(negedge wr_clk);
      chk("R5", "wr empty after 64 beats", {wr_empty, wr_count, wr_error}, {1'b1, 7'd0, 1'b0});

      // R6: pop with no armed burst, and a read command arms nothing
      push_wr(100);
      repeat (6) @(negedge ctl_clk);
      ctl_wr_pop = 1; #1;
      chk("R6", "no underrun outside burst", 64'(ctl_wr_underrun), 64'(0));
      @(negedge ctl_clk); ctl_wr_pop = 0;
      push_cmd(3'b001, 30'h0000_0200, 6'd5);
      repeat (6) @(negedge ctl_clk);
      pop_cmd("R6", 3'b001, 30'h0000_0200, 6'd5);
      @(negedge ctl_clk); ctl_wr_pop = 1; #1;
      chk("R6", "read cmd arms no burst", 64'(ctl_wr_underrun), 64'(0));
      @(negedge ctl_clk); ctl_wr_pop = 0;
      repeat (6) @(negedge wr_clk);
      chk("R6", "word kept after ignored pops", 64'(wr_count), 64'(1));

      // R7: write-with-precharge, 2 beats, only 1 word queued
      push_cmd(3'b010, 30'h0000_0300, 6'd1);
      repeat (6) @(negedge ctl_clk);
      pop_cmd("R2", 3'b010, 30'h0000_0300, 6'd1);
      @(negedge ctl_clk); ctl_wr_pop = 1; #1;
      chk("R7", "beat 0 data", {ctl_wr_mask, ctl_wr_data, ctl_wr_underrun}, {wm(100), wd(100), 1'b0});
      @(negedge ctl_clk); #1;
      chk("R7", "beat 1 underrun", 64'(ctl_wr_underrun), 64'(1));
      @(negedge ctl_clk); #1;
      chk("R7", "burst exhausted, no underrun", 64'(ctl_wr_underrun), 64'(0));
      @(negedge ctl_clk); ctl_wr_pop = 0;
      repeat (6) @(negedge wr_clk);
      chk("R7", "wr_error sticky", 64'(wr_error), 64'(1));

      // R8/R9: fill read FIFO, then overflow
      chk("R9", "rd_error before overflow", 64'(rd_error), 64'(0));
      @(negedge ctl_clk);
      for (int j = 0; j < 65; j++) begin
         ctl_rd_push = 1; ctl_rd_data = rdw(j); #1;
         chk("R9", $sformatf("overflow flag push %0d", j), 64'(ctl_rd_overflow), 64'(j == 64));
         @(negedge ctl_clk);
      end
      ctl_rd_push = 0;
      repeat (6) @(negedge rd_clk);
      chk("R8", "rd full", {rd_full, rd_count, rd_empty}, {1'b1, 7'd64, 1'b0});
      for (int j = 0; j < 64; j++) begin
         rd_en = 1; #1;
         chk("R8", $sformatf("rd word %0d", j), 64'(rd_data), 64'(rdw(j)));
         @(negedge rd_clk);
      end
      chk("R9", "dropped word absent", {rd_empty, rd_count}, {1'b1, 7'd0});
      @(negedge rd_clk); rd_en = 0;
      @(negedge ctl_clk); ctl_rd_push = 1; ctl_rd_data = rdw(200);
      @(negedge ctl_clk); ctl_rd_push = 0;
      repeat (6) @(negedge rd_clk);
      chk("R8", "pop while empty ignored", {rd_count, rd_data}, {7'd1, rdw(200)});
      chk("R9", "rd_error sticky", 64'(rd_error), 64'(1));

      // R3: command FIFO full
      chk("R3", "cmd_error before", 64'(cmd_error), 64'(0));
      push_cmd(3'b001, 30'h0000_1000, 6'd7);
      push_cmd(3'b100, 30'h0000_2000, 6'd0);
      push_cmd(3'b000, 30'h0000_3000, 6'd0);
      push_cmd(3'b011, 30'h3FFF_FFFC, 6'd63);
      chk("R2", "cmd_full after 4", {cmd_full, cmd_empty}, 2'b10);
      push_cmd(3'b000, 30'h0000_5000, 6'd2);
      chk("R3", "cmd_error set", 64'(cmd_error), 64'(1));
      repeat (6) @(negedge ctl_clk);
      pop_cmd("R3", 3'b001, 30'h0000_1000, 6'd7);
      pop_cmd("R3", 3'b100, 30'h0000_2000, 6'd0);
      pop_cmd("R3", 3'b000, 30'h0000_3000, 6'd0);
      pop_cmd("R3", 3'b011, 30'h3FFF_FFFC, 6'd63);
      @(negedge ctl_clk);
      chk("R3", "no fifth command", 64'(ctl_cmd_valid), 64'(0));
      repeat (6) @(negedge cmd_clk);
      chk("R3", "empty, error still set", {cmd_empty, cmd_error}, 2'b11);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule